// File: doc/BRIEF.md
# Programmable Sinc3 Decimation Filter

This block turns a one-bit sigma-delta modulator stream into signed 16-bit words at a lower rate. It applies a third-order sinc response, which is the cube of a length-N moving sum. Three running-sum stages update on every accepted modulator sample. Three difference stages update once per output word. A two-bit rate select sets N and with it the output rate and the notch positions. The shape of the response stays the same for every setting. Each result is scaled to 16 bits by an arithmetic right shift that depends on the setting, then clipped to the 16-bit limits.

A sync input holds the whole filter in its cleared state. Counting restarts with the first sample accepted after sync falls, so an input step can be aligned with the start of filtering. A settled flag travels with each word. It is high only on words whose whole window lies after the last restart. Three words are needed after a restart. Four are needed after a change of rate select, because the filter keeps running through such a change.

The sample stream uses valid only. `smp_valid` marks one sample, and each marked sample is taken in the cycle it is presented. A modulator cannot stall, so there is no ready. The output is a one-cycle strobe with no back-pressure. A consumer must capture `dec_data` in the cycle `dec_valid` is high. The word stays on the pins until the next strobe.

Top module: `sinc3_decimator`

## Requirements
- R1: `rate_sel` sets the decimation ratio N as 2'b00 → 384, 2'b01 → 320, 2'b10 → 76 and 2'b11 → 38. Exactly one output word is produced for every N accepted samples.
- R2: Each accepted sample counts as +1 when `smp_bit` is 1 and as −1 when it is 0. Samples before the last restart count as zero. The word is the triple moving sum of length N, taken at the sample that completes the period. It is shifted arithmetically right by 11, 10, 4 or 1 for settings 00, 01, 10 and 11, then clipped to −32768..32767.
- R3: `dec_valid` is high for exactly one cycle. That cycle directly follows the clock edge that accepts the sample completing the period. It is low out of reset.
- R4: While `sync_hold` is high, samples are discarded and no word is issued. All filter state is cleared. The first sample accepted after release starts a new period.
- R5: After reset or a sync release, the first two words carry `dec_settled` low. The third word and every later one carry it high.
- R6: When `rate_sel` differs from its value in the previous cycle (and sync is low), a new period starts and the sample of that cycle, if present, counts as its first. That cycle never completes a period. `dec_settled` stays low for the next three words and is high from the fourth.
- R7: `dec_settled` is never high unless `dec_valid` is high.
- R8: A cycle with `smp_valid` low leaves the sample count and the filter contents unchanged.
- R9: When sync, a change of rate select and a period-completing sample fall in the same cycle, sync decides: no word is issued, and the settling rule of R5 applies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| smp_valid | input | 1 | A modulator sample is present this cycle |
| smp_bit | input | 1 | Modulator bit (1 = +1, 0 = −1) |
| rate_sel | input | 2 | Decimation ratio select |
| sync_hold | input | 1 | Holds the filter cleared while high |
| dec_valid | output | 1 | One-cycle strobe for a new word |
| dec_data | output | 16 | Signed filtered word |
| dec_settled | output | 1 | The word comes from a fully settled window |

## Verification
The sharpest collision comes when a change of rate select lands in the very cycle that carries the sample that would complete the current period. The bench watches its own model's sample count and drives the change at exactly that point. It then expects no strobe in the next cycle, a fresh period that already holds that sample, and four words before the settled flag rises. A second run adds a sync pulse to the same cycle. It expects sync to win, and the flag to follow the three-word restart rule.

// File: rtl/sinc3_pkg.sv
package sinc3_pkg;

  localparam int ORDER      = 3;
  localparam int N_MAX      = 384;
  localparam int CNT_W      = $clog2(N_MAX);
  localparam int ACC_W      = 1 + ORDER * $clog2(N_MAX);
  localparam int OUT_W      = 16;
  localparam int SH_W       = 4;
  localparam int WORDS_SYNC = 3;
  localparam int WORDS_FREE = 4;
  localparam int WCNT_W     = 3;

  typedef logic [1:0] rate_t;

  function automatic int unsigned ratio_of(input rate_t r);
    case (r)
      2'b00:   return 384;
      2'b01:   return 320;
      2'b10:   return 76;
      default: return 38;
    endcase
  endfunction

  function automatic int unsigned shift_of(input rate_t r);
    case (r)
      2'b00:   return 11;
      2'b01:   return 10;
      2'b10:   return 4;
      default: return 1;
    endcase
  endfunction

endpackage

// File: rtl/sinc3_integ.sv
module sinc3_integ
  import sinc3_pkg::*;
#(
  parameter int STAGES = ORDER,
  parameter int W      = ACC_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clear,
  input  logic                step,
  input  logic                sample,
  output logic signed [W-1:0] sum_next
);

  logic signed [W-1:0] acc_q [STAGES];
  logic signed [W-1:0] feed  [STAGES+1];

  assign feed[0] = sample ? {{(W-1){1'b0}}, 1'b1} : {W{1'b1}};

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    assign feed[g+1] = acc_q[g] + feed[g];

    always_ff @(posedge clk) begin
      if (!rst_n || clear) begin
        acc_q[g] <= '0;
      end else if (step) begin
        acc_q[g] <= feed[g+1];
      end
    end
  end

  assign sum_next = feed[STAGES];

endmodule

// File: rtl/sinc3_ctrl.sv
module sinc3_ctrl
  import sinc3_pkg::*;
#(
  parameter int CW      = CNT_W,
  parameter int SW      = SH_W,
  parameter int WW      = WCNT_W,
  parameter int W_SYNC  = WORDS_SYNC,
  parameter int W_FREE  = WORDS_FREE
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sync_hold,
  input  logic          smp_valid,
  input  logic [1:0]    rate_sel,
  output logic          clear,
  output logic          step,
  output logic          fire,
  output logic          settle_ok,
  output logic [SW-1:0] shift
);

  localparam logic [WW-1:0] NEED_SYNC = WW'(W_SYNC);
  localparam logic [WW-1:0] NEED_FREE = WW'(W_FREE);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] last_idx;
  logic [1:0]    rate_q;
  logic [WW-1:0] words_q;
  logic [WW-1:0] need_q;
  logic [WW-1:0] words_inc;
  logic          rate_chg;

  assign last_idx  = CW'(ratio_of(rate_sel) - 1);
  assign shift     = SW'(shift_of(rate_sel));
  assign clear     = sync_hold;
  assign step      = smp_valid && !sync_hold;
  assign rate_chg  = !sync_hold && (rate_sel != rate_q);
  assign fire      = step && !rate_chg && (cnt_q == last_idx);
  assign words_inc = words_q + WW'(1);
  assign settle_ok = words_inc >= need_q;

  always_ff @(posedge clk) begin
    if (!rst_n || sync_hold) begin
      cnt_q   <= '0;
      rate_q  <= rate_sel;
      words_q <= '0;
      need_q  <= NEED_SYNC;
    end else begin
      rate_q <= rate_sel;
      if (rate_chg) begin
        cnt_q   <= smp_valid ? CW'(1) : '0;
        words_q <= '0;
        need_q  <= NEED_FREE;
      end else if (smp_valid) begin
        if (fire) begin
          cnt_q   <= '0;
          words_q <= (words_q >= NEED_FREE) ? words_q : words_inc;
        end else begin
          cnt_q <= cnt_q + CW'(1);
        end
      end
    end
  end

endmodule

// File: rtl/sinc3_comb.sv
module sinc3_comb
  import sinc3_pkg::*;
#(
  parameter int STAGES = ORDER,
  parameter int W      = ACC_W,
  parameter int OW     = OUT_W,
  parameter int SW     = SH_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clear,
  input  logic                 fire,
  input  logic                 settle_ok,
  input  logic signed [W-1:0]  din,
  input  logic [SW-1:0]        shift,
  output logic                 out_valid,
  output logic signed [OW-1:0] out_data,
  output logic                 out_settled
);

  localparam logic signed [W-1:0] HI = W'((1 << (OW - 1)) - 1);
  localparam logic signed [W-1:0] LO = ~HI;

  logic signed [W-1:0] dly_q [STAGES];
  logic signed [W-1:0] diff  [STAGES+1];
  logic signed [W-1:0] scaled;
  logic signed [OW-1:0] clipped;

  assign diff[0] = din;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    assign diff[g+1] = diff[g] - dly_q[g];

    always_ff @(posedge clk) begin
      if (!rst_n || clear) begin
        dly_q[g] <= '0;
      end else if (fire) begin
        dly_q[g] <= diff[g];
      end
    end
  end

  always_comb begin
    scaled = diff[STAGES] >>> shift;
    if (scaled > HI) begin
      clipped = HI[OW-1:0];
    end else if (scaled < LO) begin
      clipped = LO[OW-1:0];
    end else begin
      clipped = scaled[OW-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_settled <= 1'b0;
      out_data    <= '0;
    end else begin
      out_valid   <= fire;
      out_settled <= fire && settle_ok;
      if (fire) begin
        out_data <= clipped;
      end
    end
  end

endmodule

// File: rtl/sinc3_decimator.sv
module sinc3_decimator
  import sinc3_pkg::*;
#(
  parameter int STAGES = ORDER,
  parameter int W      = ACC_W,
  parameter int OW     = OUT_W,
  parameter int CW     = CNT_W,
  parameter int SW     = SH_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 smp_valid,
  input  logic                 smp_bit,
  input  logic [1:0]           rate_sel,
  input  logic                 sync_hold,
  output logic                 dec_valid,
  output logic signed [OW-1:0] dec_data,
  output logic                 dec_settled
);

  logic                clear;
  logic                step;
  logic                fire;
  logic                settle_ok;
  logic [SW-1:0]       shift;
  logic signed [W-1:0] sum_next;

  sinc3_ctrl #(
    .CW (CW),
    .SW (SW)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .sync_hold (sync_hold),
    .smp_valid (smp_valid),
    .rate_sel  (rate_sel),
    .clear     (clear),
    .step      (step),
    .fire      (fire),
    .settle_ok (settle_ok),
    .shift     (shift)
  );

  sinc3_integ #(
    .STAGES (STAGES),
    .W      (W)
  ) u_integ (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (clear),
    .step     (step),
    .sample   (smp_bit),
    .sum_next (sum_next)
  );

  sinc3_comb #(
    .STAGES (STAGES),
    .W      (W),
    .OW     (OW),
    .SW     (SW)
  ) u_comb (
    .clk         (clk),
    .rst_n       (rst_n),
    .clear       (clear),
    .fire        (fire),
    .settle_ok   (settle_ok),
    .din         (sum_next),
    .shift       (shift),
    .out_valid   (dec_valid),
    .out_data    (dec_data),
    .out_settled (dec_settled)
  );

endmodule

// File: rtl/sinc3_decimator_chk.sv
module sinc3_decimator_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        smp_valid,
  input logic        smp_bit,
  input logic [1:0]  rate_sel,
  input logic        sync_hold,
  input logic        dec_valid,
  input logic [15:0] dec_data,
  input logic        dec_settled
);

  logic unused_ok;
  assign unused_ok = smp_bit ^ (^dec_data);

  // R7: the settled flag only rides on a strobe
  assert_flag_on_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
    dec_settled |-> dec_valid);

  // R3: the strobe lasts a single cycle
  assert_single_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |=> !dec_valid);

  // R4: a cycle under sync never yields a word
  assert_sync_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sync_hold |=> !dec_valid);

  // R6: the cycle of a rate change never completes a period
  assert_ratechg_no_word_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rate_sel != $past(rate_sel)) |=> !dec_valid);

  // R8: every word follows an accepted sample
  assert_word_needs_sample_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dec_valid) |-> $past(smp_valid));

endmodule

bind sinc3_decimator sinc3_decimator_chk u_chk (.*);

// File: tb/tb_sinc3_decimator.sv
`timescale 1ns/1ps
module tb_sinc3_decimator;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        smp_valid = 1'b0;
  logic        smp_bit = 1'b0;
  logic [1:0]  rate_sel = 2'b11;
  logic        sync_hold = 1'b0;
  logic        dec_valid;
  logic signed [15:0] dec_data;
  logic        dec_settled;

  always #4 clk = ~clk;

  sinc3_decimator dut (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_bit(smp_bit),
    .rate_sel(rate_sel), .sync_hold(sync_hold),
    .dec_valid(dec_valid), .dec_data(dec_data), .dec_settled(dec_settled)
  );

  int total = 0;
  int bad = 0;
  int cycles = 0;
  string tag = "R3";
  bit done = 0;

  // weights of three cascaded length-N boxes, one list per setting
  int wt [4][$];
  int hist [$];
  int m_cnt = 0, m_words = 0, m_need = 3;
  logic [1:0] m_prev = 2'b11;
  bit clean = 1;
  logic e_valid = 0, e_settled = 0, e_chk = 0;
  logic signed [15:0] e_data = 0;

  function automatic int ratio(input logic [1:0] s);
    return (s == 0) ? 384 : (s == 1) ? 320 : (s == 2) ? 76 : 38;
  endfunction
  function automatic int shamt(input logic [1:0] s);
    return (s == 0) ? 11 : (s == 1) ? 10 : (s == 2) ? 4 : 1;
  endfunction

  task automatic build(input int s);
    int n = ratio(2'(s));
    int a[], b[];
    a = new[n];
    foreach (a[i]) a[i] = 1;
    for (int pass = 0; pass < 2; pass++) begin
      b = new[a.size() + n - 1];
      foreach (b[i]) begin
        b[i] = 0;
        for (int j = 0; j < n; j++)
          if (i - j >= 0 && i - j < a.size()) b[i] += a[i-j];
      end
      a = b;
    end
    wt[s].delete();
    foreach (a[i]) wt[s].push_back(a[i]);
  endtask

  function automatic logic signed [15:0] expect_word(input logic [1:0] s);
    longint y = 0;
    for (int k = 0; k < wt[s].size(); k++) begin
      int idx = hist.size() - 1 - k;
      if (idx < 0) break;
      y += longint'(wt[s][k]) * hist[idx];
    end
    y = y >>> shamt(s);
    if (y > 32767) y = 32767;
    if (y < -32768) y = -32768;
    return 16'(y);
  endfunction

  // behavioural reference, evaluated at each edge on the stable inputs
  always @(posedge clk) begin
    e_valid <= 0; e_settled <= 0; e_chk <= 0;
    if (!rst_n || sync_hold) begin
      hist.delete(); m_cnt = 0; m_words = 0; m_need = 3; clean = 1;
      m_prev = rate_sel;
      if (!rst_n) e_data <= 0;
    end else if (rate_sel != m_prev) begin
      m_prev = rate_sel; m_cnt = 0; m_words = 0; m_need = 4; clean = 0;
      if (smp_valid) begin hist.push_back(smp_bit ? 1 : -1); m_cnt = 1; end
    end else if (smp_valid) begin
      hist.push_back(smp_bit ? 1 : -1);
      if (hist.size() > 1200) void'(hist.pop_front());
      m_cnt++;
      if (m_cnt == ratio(rate_sel)) begin
        m_cnt = 0;
        if (m_words < 4) m_words++;
        e_valid   <= 1;
        e_settled <= (m_words >= m_need);
        e_chk     <= clean || (m_words >= m_need);
        e_data    <= expect_word(rate_sel);
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s (%s) actual=%0d expected=%0d at cycle %0d", req, tag, act, exp, cycles);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (rst_n && !done) begin
      check(dec_valid === e_valid, "R3 strobe", int'(dec_valid), int'(e_valid));
      check(dec_settled === e_settled, "R5 flag", int'(dec_settled), int'(e_settled));
      check(!(dec_settled && !dec_valid), "R7 flag without strobe", int'(dec_settled), 0);
      if (e_valid && e_chk)
        check(dec_data === e_data, "R2 data", int'(dec_data), int'(e_data));
    end
  end

  initial begin
    #(8 * 150000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic drive(input bit v, input bit b);
    @(negedge clk);
    smp_valid = v; smp_bit = b;
  endtask

  task automatic run(input int n, input int mode);
    for (int i = 0; i < n; i++) begin
      case (mode)
        0: drive(1, 0);
        1: drive(1, 1);
        2: drive(($urandom % 3) != 0, 1'($urandom));
        default: drive(1, 1'($urandom));
      endcase
    end
  endtask

  task automatic wait_period_end(input int n);
    while (m_cnt != n - 1) drive(1, 1'($urandom));
  endtask

  initial begin
    for (int s = 0; s < 4; s++) build(s);
    repeat (5) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    tag = "R3 reset";
    check(dec_valid === 1'b0 && dec_settled === 1'b0, "R3 reset state", int'(dec_valid), 0);

    tag = "R1 R2 N38 high";
    run(38 * 5 + 3, 1);
    tag = "R1 R6 N76 low";
    @(negedge clk); rate_sel = 2'b10;
    run(76 * 6, 0);
    tag = "R8 N320 gaps";
    @(negedge clk); rate_sel = 2'b01;
    run(320 * 8, 2);

    tag = "R4 sync held";
    sync_hold = 1;
    run(300, 3);
    rate_sel = 2'b00;
    run(5, 3);
    @(negedge clk); smp_valid = 0; sync_hold = 0;
    tag = "R4 R5 step N384";
    run(384 * 4 + 2, 1);

    tag = "R6 coincident change";
    @(negedge clk); rate_sel = 2'b11;
    run(100, 3);
    wait_period_end(38);
    @(negedge clk); rate_sel = 2'b10; smp_valid = 1; smp_bit = 1;
    run(76 * 5, 3);

    tag = "R9 sync with change";
    wait_period_end(76);
    @(negedge clk); rate_sel = 2'b11; sync_hold = 1; smp_valid = 1;
    @(negedge clk); sync_hold = 0;
    run(38 * 5, 3);
    tag = "R1 R2 N38 random";
    run(38 * 6, 3);

    repeat (4) @(negedge clk);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule